// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulation Generator

This block drives four pulse-width modulated outputs from one shared period counter. A power-of-two prescaler slows the system clock. The 15-bit counter then either climbs to a programmable top value and wraps (edge-aligned), or climbs to the top and falls back again (center-aligned). Each channel is set by a 16-bit word. The word holds a compare threshold and a polarity flag.

Software places the four words on the word bus and pulses a playback request. The block captures all four words in that same cycle. From a stopped state they take effect at once. While the block is running they are held and applied at the next period end, so no period is cut short. A stop request lets the current period finish, then parks every output at its idle level and raises a stopped flag. Playback requests are ignored while a stop is in progress.

Top module: `pwmgen`

## Requirements
- R1: After reset the block is stopped (`stopped` = 1), the counter is at 0, and every output is low, because each stored word resets to compare 0 with normal polarity.
- R2: In each 16-bit channel word, bits 14:0 are the compare value and bit 15 is polarity. With bit 15 = 1 the output is high while the channel is active. With bit 15 = 0 the output is the inverse.
- R3: A compare value of 0 keeps the channel inactive for the whole period.
- R4: A compare value greater than or equal to `countTop` keeps the channel active for the whole period. 0x7FFF always does this.
- R5: The counter takes one step every 2^`prescale` clock cycles. Counting restarts from the first cycle after a start.
- R6: In edge-aligned mode (`centerMode` = 0) the counter runs 0, 1, …, `countTop` and then wraps, giving `countTop`+1 steps per period. A channel is active while counter < compare.
- R7: In center-aligned mode (`centerMode` = 1, `countTop` ≥ 2) the counter runs 0 up to `countTop` and then down to 1, giving 2·`countTop` steps per period. A channel is active while counter < compare.
- R8: A playback request while stopped loads all four words at once. The counter is at 0 in the next cycle.
- R9: A playback request while running captures all four words at once and applies them at the first period end at or after that cycle. A playback in a period-end cycle applies at that same boundary.
- R10: A stop request while running lets generation continue until the first period end strictly after the request cycle. `stopped` rises in the following cycle. A stop given in a period-end cycle therefore waits one full further period.
- R11: Three requests are ignored: a playback while a stop is pending, a playback in the same cycle as a stop, and a stop while already stopped.
- R12: While stopped, each output holds its idle level. The idle level is the inverse of bit 15 of the last loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescale | input | PRE_W | Clock divider exponent; the counter steps every 2^prescale cycles |
| centerMode | input | 1 | 0 = edge-aligned (up only), 1 = center-aligned (up then down) |
| countTop | input | CNT_W | Period top value |
| chanWords | input | NCH*(CNT_W+1) | Channel words; channel i sits at bits [16i+15:16i] |
| playReq | input | 1 | Playback request, one-cycle pulse |
| stopReq | input | 1 | Stop request, one-cycle pulse |
| pwmOut | output | NCH | Channel outputs |
| stopped | output | 1 | High while generation is halted |

## Verification
The risky cases are control requests that land in the same cycle as each other or as a period-end step. Three such coincidences are provoked. A stop is issued exactly on a period-end cycle. A stop and a playback are issued together. A playback is issued exactly on a boundary cycle. The bench predicts each outcome from the step arithmetic: it counts cycles since the start, divides by 2^prescale and takes the result modulo the period. It then judges every output and the `stopped` flag cycle by cycle against that prediction, across all count modes, small top values and prescale settings.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic running;   // generation active (running or stop pending)
    logic tick;      // counter step enable
    logic start;     // load words directly and restart the counter
    logic capture;   // capture words into the shadow bank
    logic halt;      // period end reached while a stop is pending
  } pwmStrobes_t;

endpackage

// File: rtl/pwmgen_ctrl.sv
module pwmgen_ctrl
  import pwmgen_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescale,
  input  logic             playReq,
  input  logic             stopReq,
  input  logic             periodEnd,
  output pwmStrobes_t      strobes,
  output logic             stopped
);

  localparam int DIV_W = (1 << PRE_W) - 1;
  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_STOPPING} ctrlState_t;

  ctrlState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;

  assign divMask = ~({DIV_W{1'b1}} << prescale);

  always_comb begin
    strobes.running = (state != ST_IDLE);
    strobes.tick    = strobes.running && ((divCnt & divMask) == divMask);
    strobes.start   = (state == ST_IDLE) && playReq;
    strobes.capture = (state == ST_RUN) && playReq && !stopReq;
    strobes.halt    = (state == ST_STOPPING) && strobes.tick && periodEnd;
  end

  assign stopped = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
    end else begin
      if (strobes.start) divCnt <= '0;
      else if (strobes.running) divCnt <= divCnt + DIV_ONE;

      unique case (state)
        ST_IDLE:     if (playReq) state <= ST_RUN;
        ST_RUN:      if (stopReq) state <= ST_STOPPING;
        ST_STOPPING: if (strobes.halt) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  // With a divider above 1, two step enables never come back to back
  assert_prescale_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && prescale != '0 && $stable(prescale)) |=> !strobes.tick);

  // The stopped flag only rises after a period-end step
  assert_halt_at_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopped) |-> $past(periodEnd && strobes.tick));

  // A playback during a pending stop never restarts generation
  assert_stopping_ignores_play_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPING && playReq) |=> (state != ST_RUN));

endmodule

// File: rtl/pwmgen_dp.sv
module pwmgen_dp
  import pwmgen_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       centerMode,
  input  logic [CNT_W-1:0]           countTop,
  input  logic [NCH*(CNT_W+1)-1:0]   chanWords,
  input  pwmStrobes_t                strobes,
  output logic                       periodEnd,
  output logic [NCH-1:0]             pwmOut
);

  localparam int WORD_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [WORD_W-1:0] RESET_WORD = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0] cnt;
  logic             dirDown;
  logic             pendValid;
  logic             boundary;
  logic             applyNow;

  assign periodEnd = centerMode ? (dirDown && cnt <= ONE) : (cnt >= countTop);
  assign boundary  = strobes.tick && periodEnd;
  assign applyNow  = boundary && (strobes.capture || pendValid);

  // Shared counter: wrap in edge mode, turn around in center mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      dirDown   <= 1'b0;
      pendValid <= 1'b0;
    end else if (strobes.start) begin
      cnt       <= '0;
      dirDown   <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (strobes.halt) begin
        cnt     <= '0;
        dirDown <= 1'b0;
      end else if (strobes.tick) begin
        if (!centerMode) begin
          cnt <= (cnt >= countTop) ? '0 : cnt + ONE;
        end else if (!dirDown) begin
          if (cnt >= countTop) begin
            dirDown <= 1'b1;
            cnt     <= (countTop == '0) ? '0 : countTop - ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end else if (cnt <= ONE) begin
          dirDown <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt - ONE;
        end
      end

      if (applyNow) pendValid <= 1'b0;
      else if (strobes.capture) pendValid <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [WORD_W-1:0] actWord;
    logic [WORD_W-1:0] shadowWord;
    logic [WORD_W-1:0] inWord;
    logic [CNT_W-1:0]  cmp;
    logic              pol;
    logic              active;

    assign inWord = chanWords[g*WORD_W +: WORD_W];
    assign cmp    = actWord[CNT_W-1:0];
    assign pol    = actWord[CNT_W];
    assign active = (cmp != '0) && ((cmp >= countTop) || (cnt < cmp));
    assign pwmOut[g] = strobes.running ? (pol ? active : !active) : !pol;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actWord    <= RESET_WORD;
        shadowWord <= RESET_WORD;
      end else if (strobes.start) begin
        actWord <= inWord;
      end else if (applyNow) begin
        actWord <= strobes.capture ? inWord : shadowWord;
      end else if (strobes.capture) begin
        shadowWord <= inWord;
      end
    end

    assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rstN)
      (cmp == '0) |-> (pwmOut[g] == !pol));

    assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.running && cmp != '0 && cmp >= countTop) |-> (pwmOut[g] == pol));

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.running) |-> (pwmOut[g] != actWord[CNT_W]));
  end

  assert_idle_counter_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.running) |-> (cnt == '0 && !dirDown));

  assert_center_turn_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && centerMode && dirDown && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/pwmgen.sv
module pwmgen
  import pwmgen_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 15,
  parameter int PRE_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PRE_W-1:0]         prescale,
  input  logic                     centerMode,
  input  logic [CNT_W-1:0]         countTop,
  input  logic [NCH*(CNT_W+1)-1:0] chanWords,
  input  logic                     playReq,
  input  logic                     stopReq,
  output logic [NCH-1:0]           pwmOut,
  output logic                     stopped
);

  pwmStrobes_t strobes;
  logic        periodEnd;

  pwmgen_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .prescale  (prescale),
    .playReq   (playReq),
    .stopReq   (stopReq),
    .periodEnd (periodEnd),
    .strobes   (strobes),
    .stopped   (stopped)
  );

  pwmgen_dp #(.NCH(NCH), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .centerMode (centerMode),
    .countTop   (countTop),
    .chanWords  (chanWords),
    .strobes    (strobes),
    .periodEnd  (periodEnd),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/pwmgen_tb.sv
module pwmgen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  prescale = '0;
  logic        centerMode = 1'b0;
  logic [14:0] countTop = 15'd1;
  logic [63:0] chanWords = '0;
  logic        playReq = 1'b0;
  logic        stopReq = 1'b0;
  logic [3:0]  pwmOut;
  logic        stopped;

  int checks = 0;
  int errors = 0;

  int gMode, gTop, gP;
  int kSwitch, ks, kEnd;
  logic [15:0] oldW [4];
  logic [15:0] newW [4];
  logic [15:0] junkW [4];

  always #2 clk = ~clk;

  pwmgen u_dut (
    .clk(clk), .rstN(rstN), .prescale(prescale), .centerMode(centerMode),
    .countTop(countTop), .chanWords(chanWords), .playReq(playReq),
    .stopReq(stopReq), .pwmOut(pwmOut), .stopped(stopped)
  );

  function automatic int periodTicks();
    return gMode ? 2 * gTop : gTop + 1;
  endfunction

  function automatic bit isBoundary(int kk);
    int div = 1 << gP;
    return ((kk % div) == div - 1) && (((kk / div) % periodTicks()) == periodTicks() - 1);
  endfunction

  function automatic int firstBoundary(int from);
    for (int kk = from; kk < from + 100000; kk++)
      if (isBoundary(kk)) return kk;
    return -1;
  endfunction

  function automatic bit expOut(int kk, logic [15:0] w);
    int t = kk >> gP;
    int ph = t % periodTicks();
    int c = gMode ? ((ph <= gTop) ? ph : 2 * gTop - ph) : ph;
    int cmp = int'(w[14:0]);
    bit act = (cmp != 0) && ((cmp >= gTop) || (c < cmp));
    return w[15] ? act : !act;
  endfunction

  function automatic logic [63:0] pack(logic [15:0] w [4]);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = w[i];
    return r;
  endfunction

  task automatic check1(string req, string what, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, actual, expected);
    end
  endtask

  task automatic checkCycle(int k, int variant);
    for (int ch = 0; ch < 4; ch++) begin
      logic [15:0] w;
      logic e;
      string req;
      w = (k > kSwitch) ? newW[ch] : oldW[ch];
      if (k > kEnd) begin
        e = !newW[ch][15];
        req = "R12";
      end else begin
        e = expOut(k, w);
        if (k > ks) req = (variant != 0) ? "R11" : "R10";
        else if (k > kSwitch) req = "R9";
        else if (k == 0) req = "R8";
        else if (!w[15]) req = "R2";
        else if (w[14:0] == 0) req = "R3";
        else if (int'(w[14:0]) >= gTop) req = "R4";
        else if (gP > 0) req = "R5";
        else req = gMode ? "R7" : "R6";
      end
      check1(req, $sformatf("out%0d k=%0d mode=%0d top=%0d p=%0d", ch, k, gMode, gTop, gP),
             pwmOut[ch], e);
    end
    check1("R10", $sformatf("stopped k=%0d", k), stopped, k > kEnd);
  endtask

  task automatic runConfig(int mode, int top, int p, int variant);
    int kp;
    gMode = mode; gTop = top; gP = p;
    centerMode = mode[0];
    countTop = 15'(top);
    prescale = 3'(p);
    oldW[0] = 16'h8000;
    oldW[1] = {1'b1, 15'(top + variant)};
    oldW[2] = {1'b1, 15'(1 + ((top + p + variant) % top))};
    oldW[3] = {1'b0, 15'(top / 2)};
    newW[0] = {1'b0, 15'(top - 1)};
    newW[1] = 16'hFFFF;
    newW[2] = 16'h0000;
    newW[3] = {1'b1, 15'((top + 1) / 2)};
    for (int i = 0; i < 4; i++) junkW[i] = {~newW[i][15], 15'd0};

    if (variant == 2) kp = firstBoundary(0);
    else kp = (periodTicks() << p) / 2 + variant;
    kSwitch = firstBoundary(kp);
    if (variant == 0) ks = firstBoundary(kSwitch + 1);
    else ks = kSwitch + 2;
    kEnd = firstBoundary(ks + 1);

    chanWords = pack(oldW);
    playReq = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= kEnd + 3; k++) begin
      checkCycle(k, variant);
      playReq = 1'b0;
      stopReq = 1'b0;
      if (k == kp) begin
        playReq = 1'b1;
        chanWords = pack(newW);
      end
      if (k == ks) begin
        stopReq = 1'b1;
        if (variant == 1) begin
          playReq = 1'b1;
          chanWords = pack(junkW);
        end
      end
      if (variant == 2 && k == ks + 1) begin
        playReq = 1'b1;
        chanWords = pack(junkW);
      end
      @(negedge clk);
    end
    playReq = 1'b0;
    stopReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1", "stopped after reset", stopped, 1'b1);
    for (int ch = 0; ch < 4; ch++)
      check1("R1", $sformatf("out%0d after reset", ch), pwmOut[ch], 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1", "stopped after release", stopped, 1'b1);

    for (int mode = 0; mode < 2; mode++)
      for (int top = (mode == 1) ? 2 : 1; top <= 5; top++)
        for (int p = 0; p < 3; p++)
          for (int variant = 0; variant < 3; variant++)
            runConfig(mode, top, p, variant);

    // R11: stop while already stopped has no effect
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check1("R11", "stopped after idle stop", stopped, 1'b1);
      for (int ch = 0; ch < 4; ch++)
        check1("R11", $sformatf("out%0d after idle stop", ch), pwmOut[ch], !newW[ch][15]);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule